// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block cuts a peripheral clock into time quanta and walks each nominal CAN bit through three phases: one sync quantum, a first phase segment and a second phase segment. On the last clock of the first phase segment it raises a one-clock sample strobe and captures the receive line. On the first clock of every bit it raises a one-clock bit-start strobe, which a transmitter uses as its drive point.

The quantum length and both segment lengths come from one packed 32-bit timing word. Each field holds its length minus one. A falling edge on the receive line marks a recessive-to-dominant transition, with logic 1 taken as recessive. Such an edge resynchronises the bit once per bit time. It lengthens the first segment or shortens the second, limited by a programmable jump width.

The timing word may only be written while the block is disabled. Raising the enable starts a fresh bit from the first clock of its sync quantum.

Top module: `can_bit_timer`

## Requirements
- R1: One quantum lasts (P+1) clocks, where P is timing word bits 9:0. With no resynchronising edge, a bit lasts 1 + (A+1) + (B+1) quanta, where A is bits 19:16 and B is bits 22:20.
- R2: `bit_start` is high for exactly the first clock of each bit. This includes the first clock on which `en` is high after being low. It is never high in the same clock as `sample_stb`.
- R3: `sample_stb` is high for one clock, the last clock of the first phase segment. With no edge, that is clock (P+1)*(A+2)-1 counted from 0 at `bit_start`. `rx_bit` takes the value of `rx` at that clock edge and holds it at all other times. `rx_bit` is 1 after reset.
- R4: A write (`cfg_we` high) stores `cfg_wdata` only in a clock where `en` is low. In any clock with `en` high the write is ignored and `cfg_rdata` does not change.
- R5: `cfg_rdata` returns the stored fields at bits 9:0, 19:16, 22:20 and 25:24. Every other bit reads 0, including 15:10 and 23. It reads 0 after reset.
- R6: Let J = (bits 25:24) + 1. A clock in which `rx` is 0 and was 1 in the previous clock is an edge. An edge that falls in quantum k of the bit (sync quantum is k=0) while the first phase segment is running extends that segment by min(k, J) quanta. This moves both the sample point and the end of the bit.
- R7: An edge in quantum i (from 0) of the second phase segment sets that segment's length to max(i+1, B+1-J) quanta.
- R8: An edge inside the sync quantum changes nothing and does not use up the bit's resynchronisation. After one resynchronisation, further edges in the same bit change nothing.
- R9: While `en` is low, both strobes stay low and the bit position is held at the start of a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the sequencer at bit start |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_wdata | input | 32 | Timing word to store |
| cfg_rdata | output | 32 | Stored timing word, unused bits zero |
| rx | input | 1 | Bus receive level, 1 = recessive |
| rx_bit | output | 1 | Level captured at the last sample point |
| sample_stb | output | 1 | One-clock sample point strobe |
| bit_start | output | 1 | One-clock strobe on the first clock of each bit |

## Verification
The hardest cases to reach are edges at the boundaries between segments. Examples are an edge on the final clock of the first segment, an edge in the last quantum of the second segment, and a second edge in a bit that has already resynchronised. In all of these the jump width decides whether the sample strobe moves and by how much.

The bench restarts the block for every clock offset across a whole bit. At each offset it drops the line, lets it rise and drops it again, so every phase and every follow-up edge is covered. Random line activity is then run under several timing words, including the largest segments with the widest jump and the one-quantum segments. A behavioural model written in clock positions predicts every output on every clock.

// File: rtl/can_bit_timer.sv
module can_bit_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        rx,
  output logic        rx_bit,
  output logic        sample_stb,
  output logic        bit_start
);
  localparam logic [31:0] FIELD_MASK = 32'h037F_03FF;

  typedef enum logic [1:0] {PH_SYNC, PH_ONE, PH_TWO} phase_e;

  logic [31:0] cfg_q;
  logic [9:0]  presc, pc;
  logic [3:0]  len1_f;
  logic [2:0]  len2_f;
  logic [1:0]  jump_f;
  phase_e      ph;
  logic [4:0]  qcnt, len, len_eff, jq, ext, shrunk, floor2;
  logic        rs_done, rx_q, tq_end, rs, seg_last;

  assign presc     = cfg_q[9:0];
  assign len1_f    = cfg_q[19:16];
  assign len2_f    = cfg_q[22:20];
  assign jump_f    = cfg_q[25:24];
  assign cfg_rdata = cfg_q;

  assign jq     = 5'(jump_f) + 5'd1;
  assign tq_end = en && (pc == presc);
  assign rs     = en && rx_q && !rx && !rs_done && (ph != PH_SYNC);
  assign floor2 = qcnt + 5'd1;
  assign ext    = (floor2 < jq) ? floor2 : jq;
  assign shrunk = (len > jq) ? len - jq : 5'd0;

  always_comb begin
    len_eff = len;
    if (rs && ph == PH_ONE)      len_eff = len + ext;
    else if (rs && ph == PH_TWO) len_eff = (shrunk > floor2) ? shrunk : floor2;
  end

  assign seg_last   = tq_end && (qcnt == len_eff - 5'd1);
  assign sample_stb = seg_last && (ph == PH_ONE);
  assign bit_start  = en && (ph == PH_SYNC) && (pc == 10'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cfg_q <= '0;
    else if (cfg_we && !en)    cfg_q <= cfg_wdata & FIELD_MASK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_q   <= 1'b1;
      rx_bit <= 1'b1;
    end else begin
      rx_q <= rx;
      if (sample_stb) rx_bit <= rx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pc      <= '0;
      ph      <= PH_SYNC;
      qcnt    <= '0;
      len     <= 5'd1;
      rs_done <= 1'b0;
    end else if (!en) begin
      pc      <= '0;
      ph      <= PH_SYNC;
      qcnt    <= '0;
      len     <= 5'd1;
      rs_done <= 1'b0;
    end else begin
      pc  <= tq_end ? 10'd0 : pc + 10'd1;
      len <= len_eff;
      if (rs) rs_done <= 1'b1;
      if (tq_end) begin
        if (seg_last) begin
          qcnt <= '0;
          case (ph)
            PH_SYNC: begin ph <= PH_ONE; len <= 5'(len1_f) + 5'd1; end
            PH_ONE:  begin ph <= PH_TWO; len <= 5'(len2_f) + 5'd1; end
            default: begin ph <= PH_SYNC; len <= 5'd1; rs_done <= 1'b0; end
          endcase
        end else begin
          qcnt <= qcnt + 5'd1;
        end
      end
    end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !en |-> (!sample_stb && !bit_start)); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) en |=> $stable(cfg_rdata)); // R4
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (cfg_rdata & ~FIELD_MASK) == 32'd0); // R5
  AST_RXBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !sample_stb |=> $stable(rx_bit)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(sample_stb && bit_start)); // R2
  AST_PC_BOUND: assert property (@(posedge clk) disable iff (!rst_n) pc <= presc); // R1
  AST_SEG1_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (ph == PH_ONE) |-> (qcnt < 5'(len1_f) + jq + 5'd1)); // R6
  AST_SEG2_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (ph == PH_TWO) |-> (qcnt <= 5'(len2_f))); // R7
endmodule

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        rx = 1'b1;
  logic [31:0] cfg_rdata;
  logic        rx_bit, sample_stb, bit_start;

  can_bit_timer dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rx(rx), .rx_bit(rx_bit), .sample_stb(sample_stb),
    .bit_start(bit_start)
  );

  always #5 clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  string tag = "reset";
  bit    done = 1'b0;

  int          c = 0, sample_at = 0, end_at = 0;
  bit          resynced = 1'b0;
  logic        prev_rx = 1'b1;
  logic        m_rxbit = 1'b1;
  logic [31:0] m_cfg = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] act=%h exp=%h t=%0t", req, tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic e, input logic r, input logic we = 1'b0, input logic [31:0] wd = '0);
    int q, p, a, b, j, k, ext, s2, qi, len2, nl;
    logic exp_bs, exp_ss;
    @(negedge clk);
    en = e; rx = r; cfg_we = we; cfg_wdata = wd;
    #1;
    p = int'(m_cfg[9:0]); a = int'(m_cfg[19:16]); b = int'(m_cfg[22:20]); j = int'(m_cfg[25:24]) + 1;
    q = p + 1;
    exp_bs = 1'b0; exp_ss = 1'b0;
    if (e) begin
      if (c == 0) begin
        sample_at = q * (a + 2) - 1;
        end_at    = q * (a + b + 3) - 1;
        resynced  = 1'b0;
      end
      if (prev_rx && !r && !resynced && c >= q) begin
        k = c / q;
        resynced = 1'b1;
        if (c <= sample_at) begin
          ext = (k < j) ? k : j;
          sample_at += ext * q;
          end_at    += ext * q;
        end else begin
          s2   = (sample_at + 1) / q;
          qi   = k - s2;
          len2 = (end_at + 1) / q - s2;
          nl   = len2 - j;
          if (nl < qi + 1) nl = qi + 1;
          end_at = (s2 + nl) * q - 1;
        end
      end
      exp_bs = (c == 0);
      exp_ss = (c == sample_at);
    end
    chk("R2 bit_start", 32'(bit_start), 32'(exp_bs));
    chk("R3 sample_stb", 32'(sample_stb), 32'(exp_ss));
    chk("R3 rx_bit", 32'(rx_bit), 32'(m_rxbit));
    chk("R5 cfg_rdata", cfg_rdata, m_cfg);
    if (e && exp_ss) m_rxbit = r;
    if (e) c = (c == end_at) ? 0 : c + 1;
    else   c = 0;
    if (we && !e) m_cfg = {6'b0, wd[25:24], 1'b0, wd[22:20], wd[19:16], 6'b0, wd[9:0]};
    prev_rx = r;
  endtask

  task automatic load(input logic [31:0] wd);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b1, wd);
    step(1'b0, 1'b1);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state and quiet while disabled
    tag = "R9 reset";
    repeat (4) step(1'b0, 1'b1);
    // R5: reserved bits dropped on write
    tag = "R5 reserved";
    load(32'hFDA4_FC02);
    // R1 R2 R3: plain bits, no edges (P=2, A=4, B=2, J=2)
    tag = "R1 nominal";
    repeat (100) step(1'b1, 1'b1);
    // R4: write while enabled is ignored
    tag = "R4 locked";
    step(1'b1, 1'b1, 1'b1, 32'h0000_0000);
    repeat (10) step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    chk("R4 cfg_rdata kept", cfg_rdata, 32'h0124_0002);
    // R6 R7 R8: edge at every offset, then a second edge in the same bit
    tag = "R6_R7_R8 sweep";
    for (int off = 0; off < 36; off++) begin
      step(1'b0, 1'b1);
      repeat (off) step(1'b1, 1'b1);
      repeat (4) step(1'b1, 1'b0);
      repeat (3) step(1'b1, 1'b1);
      step(1'b1, 1'b0);
      repeat (40) step(1'b1, 1'b1);
    end
    // R6 R7: random line activity under several timing words
    tag = "R6_R7 random";
    for (int cf = 0; cf < 4; cf++) begin
      logic lvl;
      case (cf)
        0: load(32'h037F_0000);
        1: load(32'h0000_0001);
        2: load(32'h0237_0004);
        default: load(32'h0124_0002);
      endcase
      lvl = 1'b1;
      for (int n = 0; n < 1500; n++) begin
        if ($urandom_range(0, 5) == 0) lvl = ~lvl;
        step(1'b1, lvl);
      end
    end
    // R9: disable mid bit, restart from bit start
    tag = "R9 restart";
    repeat (17) step(1'b1, 1'b1);
    repeat (3) step(1'b0, 1'b1);
    repeat (50) step(1'b1, 1'b1);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule